// File: doc/BRIEF.md
# Owner-Tagged Translation Buffer Pair with Reclaim Walker

The block holds two small translation buffers for a local store. The forward buffer maps a virtual page number to a physical page number. The reverse buffer maps a physical page number from an incoming coherence message back to a virtual page number. Both are looked up combinationally. Every entry also records the index of the mapping-table entry whose addresses it covers (its owner). Entries are filled from outside through one insert port. A direction bit on that port selects which buffer is written.

When a mapping entry is retired, a sequential walker clears every entry in both buffers whose owner matches the retired index. It visits one slot of each buffer per cycle. A retirement can be requested explicitly through a request/done handshake. Retirement can also be deferred: a finished kernel's mapping index is pushed into a small first-in first-out queue, and its entries stay usable. Only when an insertion finds its target buffer full does the block pop the oldest queued index and walk it. After that walk the insertion is retried.

Top module: `bp_xlate_reclaim`

## Requirements
- R1: After reset, every entry of both buffers is invalid: fwd_hit and rev_hit are 0, rel_done is 0, and ins_ready is 1.
- R2: An insertion is taken on a clock edge where ins_valid and ins_ready are both 1. ins_dir=0 writes the forward buffer, keyed by ins_vpn and returning ins_ppn. ins_dir=1 writes the reverse buffer, keyed by ins_ppn and returning ins_vpn. The entry goes into the lowest-numbered free slot of that buffer, and ins_map is stored as its owner.
- R3: fwd_hit is 1 in the same cycle when a valid forward entry holds key fwd_vpn, and fwd_ppn then carries its stored physical page; a key present only in the reverse buffer gives a forward miss.
- R4: rev_hit is 1 in the same cycle when a valid reverse entry holds key rev_ppn, and rev_vpn then carries its stored virtual page; a key present only in the forward buffer gives a reverse miss.
- R5: rel_req sampled high while no walk runs starts a walk for rel_map. rel_done is 1 for exactly one cycle, the 16th cycle after acceptance. After that, all entries in both buffers owned by rel_map are invalid, and entries with other owners still hit.
- R6: In the k-th cycle of a walk (k = 0..15) the walker visits slot k of both buffers. A lookup that hits slot k, when that slot's owner equals the walk's index, reports a miss in that cycle. Matching entries in later slots still hit.
- R7: ins_ready is 0 while a walk runs or rel_req is 1. A held insertion is taken only after the walk ends.
- R8: kend_valid pushes kend_map into the completed-kernel queue. The entries of that index remain valid and keep hitting.
- R9: An insertion whose target buffer is full, when the queue is not empty, pops the oldest index and walks it. rel_done stays 0 during such a walk. The insertion is then taken into the lowest freed slot.
- R10: The queue releases indices oldest first, so a later full-buffer insertion reclaims the next queued index.
- R11: With the target buffer full and the queue empty, ins_ready stays 0 and no entry is cleared. The other buffer's ready is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_vpn | input | VPN_W | Forward lookup virtual page |
| fwd_hit | output | 1 | Forward lookup hit |
| fwd_ppn | output | PPN_W | Forward lookup result |
| rev_ppn | input | PPN_W | Reverse lookup physical page |
| rev_hit | output | 1 | Reverse lookup hit |
| rev_vpn | output | VPN_W | Reverse lookup result |
| ins_valid | input | 1 | Insertion request |
| ins_dir | input | 1 | Target buffer: 0 forward, 1 reverse |
| ins_vpn | input | VPN_W | Virtual page of the new entry |
| ins_ppn | input | PPN_W | Physical page of the new entry |
| ins_map | input | MAP_W | Owner index of the new entry |
| ins_ready | output | 1 | Insertion accepted this cycle when valid |
| rel_req | input | 1 | Explicit release request, held until rel_done |
| rel_map | input | MAP_W | Index to release |
| rel_done | output | 1 | Explicit release finished |
| kend_valid | input | 1 | Kernel-finished push |
| kend_map | input | MAP_W | Index of the finished kernel |

## Verification
The assertions take several things as given about the inputs. The completed-kernel queue is never pushed while full. rel_req stays high from its request until rel_done. Two entries in one buffer never share a key. Insertions are never attempted into a buffer that is full while the queue is empty, except in the one test of that stall. The stimulus keeps within these limits. It pushes at most two indices into a four-deep queue. It uses distinct page numbers for every entry, and it drops rel_req in the cycle where rel_done is seen. The full-buffer stall is probed only by holding ins_valid for a bounded time and then withdrawing it.

// File: rtl/bpx_pkg.sv
package bpx_pkg;
  typedef enum logic {
    BUF_FWD = 1'b0,
    BUF_REV = 1'b1
  } buf_sel_e;

  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/bpx_buffer.sv
module bpx_buffer #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 20,
  parameter int VAL_W   = 20,
  parameter int OWN_W   = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] lk_key,
  output logic             lk_hit,
  output logic [VAL_W-1:0] lk_val,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [VAL_W-1:0] wr_val,
  input  logic [OWN_W-1:0] wr_own,
  output logic             has_free,
  input  logic             clr_on,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [OWN_W-1:0] clr_own
);
  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [KEY_W-1:0]   key_q [ENTRIES];
  logic [VAL_W-1:0]   val_q [ENTRIES];
  logic [OWN_W-1:0]   own_q [ENTRIES];
  logic [ENTRIES-1:0] kill_vec;
  logic [IDX_W-1:0]   free_idx;

  // slot under the walker whose owner matches is dropped this cycle
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      kill_vec[i] = clr_on && (clr_idx == IDX_W'(i)) && vld_q[i] && (own_q[i] == clr_own);
    end
  end

  // lowest free slot and lookup (lowest index wins)
  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    lk_hit   = 1'b0;
    lk_val   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (vld_q[i] && !kill_vec[i] && (key_q[i] == lk_key)) begin
        lk_hit = 1'b1;
        lk_val = val_q[i];
      end
    end
  end

  always_comb begin
    vld_d = vld_q & ~kill_vec;
    if (wr_en) vld_d[free_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      key_q[free_idx] <= wr_key;
      val_q[free_idx] <= wr_val;
      own_q[free_idx] <= wr_own;
    end
  end

  p_write_has_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> has_free);

  p_cleared_slot_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_on && kill_vec[clr_idx]) |=> !vld_q[$past(clr_idx)]);

  p_walk_blocks_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_on |-> !wr_en);
endmodule

// File: rtl/bpx_walker.sv
module bpx_walker #(
  parameter int ENTRIES = 16,
  parameter int OWN_W   = 3,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_expl,
  input  logic             start_lazy,
  input  logic [OWN_W-1:0] start_own,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic [OWN_W-1:0] own,
  output logic             done
);
  import bpx_pkg::*;

  walk_state_e      st_q, st_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic [OWN_W-1:0] own_q, own_d;
  logic             expl_q, expl_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    own_d  = own_q;
    expl_d = expl_q;
    case (st_q)
      WK_IDLE: if (start_expl || start_lazy) begin
        st_d   = WK_RUN;
        cnt_d  = '0;
        own_d  = start_own;
        expl_d = start_expl;
      end
      WK_RUN: begin
        if (cnt_q == LAST) st_d = WK_IDLE;
        else               cnt_d = cnt_q + 1'b1;
      end
      default: st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WK_IDLE;
      cnt_q  <= '0;
      own_q  <= '0;
      expl_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      own_q  <= own_d;
      expl_q <= expl_d;
    end
  end

  assign busy = (st_q == WK_RUN);
  assign idx  = cnt_q;
  assign own  = own_q;
  assign done = busy && expl_q && (cnt_q == LAST);

  p_walk_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q == LAST) |=> !busy);

  p_walk_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != LAST) |=> (busy && cnt_q == $past(cnt_q) + 1'b1));

  p_walk_starts_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cnt_q == '0));

  p_done_explicit_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> expl_q);
endmodule

// File: rtl/bpx_kfifo.sv
module bpx_kfifo #(
  parameter int DEPTH  = 4,
  parameter int OWN_W  = 3,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [OWN_W-1:0] push_own,
  input  logic             pop,
  output logic [OWN_W-1:0] head,
  output logic             empty,
  output logic             full
);
  logic [OWN_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_own;
  end

  p_no_push_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  p_no_pop_when_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/bp_xlate_reclaim.sv
module bp_xlate_reclaim #(
  parameter int ENTRIES  = 16,
  parameter int VPN_W    = 20,
  parameter int PPN_W    = 20,
  parameter int MAP_W    = 3,
  parameter int KQ_DEPTH = 4,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] fwd_vpn,
  output logic             fwd_hit,
  output logic [PPN_W-1:0] fwd_ppn,
  input  logic [PPN_W-1:0] rev_ppn,
  output logic             rev_hit,
  output logic [VPN_W-1:0] rev_vpn,
  input  logic             ins_valid,
  input  logic             ins_dir,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic [MAP_W-1:0] ins_map,
  output logic             ins_ready,
  input  logic             rel_req,
  input  logic [MAP_W-1:0] rel_map,
  output logic             rel_done,
  input  logic             kend_valid,
  input  logic [MAP_W-1:0] kend_map
);
  import bpx_pkg::*;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             walk_busy, fwd_free, rev_free, tgt_free;
  logic [IDX_W-1:0] walk_idx;
  logic [MAP_W-1:0] walk_own, q_head, start_own;
  logic             q_empty, q_full, idle, start_expl, start_lazy, ins_go;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign idle       = !walk_busy;
  assign tgt_free   = (buf_sel_e'(ins_dir) == BUF_REV) ? rev_free : fwd_free;
  assign ins_ready  = idle && !rel_req && tgt_free;
  assign ins_go     = ins_valid && ins_ready;
  assign start_expl = idle && rel_req;
  assign start_lazy = idle && !rel_req && ins_valid && !tgt_free && !q_empty;
  assign start_own  = rel_req ? rel_map : q_head;

  bpx_buffer #(.ENTRIES(ENTRIES), .KEY_W(VPN_W), .VAL_W(PPN_W), .OWN_W(MAP_W)) u_fwd (
    .clk(clk), .rst_n(rst_int_n),
    .lk_key(fwd_vpn), .lk_hit(fwd_hit), .lk_val(fwd_ppn),
    .wr_en(ins_go && (buf_sel_e'(ins_dir) == BUF_FWD)),
    .wr_key(ins_vpn), .wr_val(ins_ppn), .wr_own(ins_map),
    .has_free(fwd_free),
    .clr_on(walk_busy), .clr_idx(walk_idx), .clr_own(walk_own)
  );

  bpx_buffer #(.ENTRIES(ENTRIES), .KEY_W(PPN_W), .VAL_W(VPN_W), .OWN_W(MAP_W)) u_rev (
    .clk(clk), .rst_n(rst_int_n),
    .lk_key(rev_ppn), .lk_hit(rev_hit), .lk_val(rev_vpn),
    .wr_en(ins_go && (buf_sel_e'(ins_dir) == BUF_REV)),
    .wr_key(ins_ppn), .wr_val(ins_vpn), .wr_own(ins_map),
    .has_free(rev_free),
    .clr_on(walk_busy), .clr_idx(walk_idx), .clr_own(walk_own)
  );

  bpx_walker #(.ENTRIES(ENTRIES), .OWN_W(MAP_W)) u_walk (
    .clk(clk), .rst_n(rst_int_n),
    .start_expl(start_expl), .start_lazy(start_lazy), .start_own(start_own),
    .busy(walk_busy), .idx(walk_idx), .own(walk_own), .done(rel_done)
  );

  bpx_kfifo #(.DEPTH(KQ_DEPTH), .OWN_W(MAP_W)) u_kq (
    .clk(clk), .rst_n(rst_int_n),
    .push(kend_valid), .push_own(kend_map), .pop(start_lazy),
    .head(q_head), .empty(q_empty), .full(q_full)
  );

  p_release_starts_walk_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rel_req && !walk_busy) |=> (walk_busy && walk_own == $past(rel_map)));

  p_lazy_needs_full_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($rose(walk_busy) && !$past(rel_req)) |-> ($past(ins_valid) && !$past(tgt_free)));

  p_queue_room_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    kend_valid |-> !q_full);
endmodule

// File: tb/bp_xlate_reclaim_test.sv
module bp_xlate_reclaim_test;
  localparam int K_FWD = 0, K_REV = 1, K_RDY = 2, K_DONE = 3;

  typedef struct {
    int          kind;
    logic        exp_b;
    logic [31:0] exp_v;
    string       tag;
  } item_t;

  logic        clk, rst_n;
  logic [19:0] fwd_vpn, fwd_ppn, rev_ppn, rev_vpn, ins_vpn, ins_ppn;
  logic        fwd_hit, rev_hit, ins_valid, ins_dir, ins_ready, rel_req, rel_done, kend_valid;
  logic [2:0]  ins_map, rel_map, kend_map;
  item_t       q[$];
  int          checks = 0, fails = 0;

  bp_xlate_reclaim uut (
    .clk(clk), .rst_n(rst_n),
    .fwd_vpn(fwd_vpn), .fwd_hit(fwd_hit), .fwd_ppn(fwd_ppn),
    .rev_ppn(rev_ppn), .rev_hit(rev_hit), .rev_vpn(rev_vpn),
    .ins_valid(ins_valid), .ins_dir(ins_dir), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn),
    .ins_map(ins_map), .ins_ready(ins_ready),
    .rel_req(rel_req), .rel_map(rel_map), .rel_done(rel_done),
    .kend_valid(kend_valid), .kend_map(kend_map)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic report(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        case (it.kind)
          K_FWD:   report(it.tag, it.exp_b ? {11'd0, fwd_hit, fwd_ppn} : {31'd0, fwd_hit},
                          it.exp_b ? {11'd0, 1'b1, it.exp_v[19:0]} : 32'd0);
          K_REV:   report(it.tag, it.exp_b ? {11'd0, rev_hit, rev_vpn} : {31'd0, rev_hit},
                          it.exp_b ? {11'd0, 1'b1, it.exp_v[19:0]} : 32'd0);
          K_RDY:   report(it.tag, {31'd0, ins_ready}, {31'd0, it.exp_b});
          default: report(it.tag, {31'd0, rel_done}, {31'd0, it.exp_b});
        endcase
      end
    end
  end

  task automatic exp_fwd(logic [19:0] vpn, logic hit, logic [19:0] ppn, string tag);
    fwd_vpn = vpn;
    q.push_back('{K_FWD, hit, {12'd0, ppn}, tag});
  endtask

  task automatic exp_rev(logic [19:0] ppn, logic hit, logic [19:0] vpn, string tag);
    rev_ppn = ppn;
    q.push_back('{K_REV, hit, {12'd0, vpn}, tag});
  endtask

  task automatic exp_bit(int kind, logic b, string tag);
    q.push_back('{kind, b, 32'd0, tag});
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic insert(logic dir, logic [19:0] vpn, logic [19:0] ppn, logic [2:0] map, string tag);
    int n;
    @(negedge clk);
    ins_valid = 1'b1; ins_dir = dir; ins_vpn = vpn; ins_ppn = ppn; ins_map = map;
    #1;
    n = 0;
    while (!ins_ready && n < 64) begin
      @(negedge clk);
      #1;
      n++;
    end
    if (!ins_ready) report(tag, 32'd0, 32'd1);
    @(posedge clk);
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic kend(logic [2:0] map);
    @(negedge clk);
    kend_valid = 1'b1; kend_map = map;
    @(negedge clk);
    kend_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog (all requirements): got hung run expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fwd_vpn = '0; rev_ppn = '0; ins_valid = 1'b0; ins_dir = 1'b0;
    ins_vpn = '0; ins_ppn = '0; ins_map = '0; rel_req = 1'b0; rel_map = '0;
    kend_valid = 1'b0; kend_map = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    exp_fwd(20'h00100, 1'b0, '0, "R1 fwd miss");
    exp_rev(20'h00B00, 1'b0, '0, "R1 rev miss");
    exp_bit(K_RDY, 1'b1, "R1 ready");
    exp_bit(K_DONE, 1'b0, "R1 done low");

    // fills: fwd slots 0..2, rev slots 0..1
    insert(1'b0, 20'h00100, 20'h00A00, 3'd1, "R2 ins");
    insert(1'b0, 20'h00101, 20'h00A01, 3'd2, "R2 ins");
    insert(1'b0, 20'h00102, 20'h00A02, 3'd1, "R2 ins");
    insert(1'b1, 20'h00300, 20'h00B00, 3'd1, "R2 ins");
    insert(1'b1, 20'h00301, 20'h00B01, 3'd3, "R2 ins");
    exp_fwd(20'h00101, 1'b1, 20'h00A01, "R3 fwd hit");
    exp_rev(20'h00B00, 1'b1, 20'h00300, "R4 rev hit");
    step();
    exp_fwd(20'h00B00, 1'b0, '0, "R2 R3 reverse key not in fwd");
    exp_rev(20'h00100, 1'b0, '0, "R2 R4 forward key not in rev");
    step();

    // explicit release of owner 1 (N0)
    rel_req = 1'b1; rel_map = 3'd1;
    exp_bit(K_RDY, 1'b0, "R7 ready low on request");
    step(); // N1, slot 0
    exp_fwd(20'h00100, 1'b0, '0, "R6 fwd slot0 killed in its cycle");
    exp_rev(20'h00B00, 1'b0, '0, "R6 rev slot0 killed in its cycle");
    step(); // N2, slot 1
    exp_fwd(20'h00102, 1'b1, 20'h00A02, "R6 later slot still hits");
    step(); // N3, slot 2
    exp_fwd(20'h00102, 1'b0, '0, "R6 slot2 killed in its cycle");
    step(); step(); // N5
    ins_valid = 1'b1; ins_dir = 1'b0; ins_vpn = 20'h00200; ins_ppn = 20'h00C00; ins_map = 3'd4;
    exp_bit(K_RDY, 1'b0, "R7 ready low during walk");
    repeat (10) step(); // N15
    exp_bit(K_DONE, 1'b0, "R5 done not early");
    step(); // N16
    exp_bit(K_DONE, 1'b1, "R5 done on 16th cycle");
    rel_req = 1'b0;
    step(); // N17
    exp_bit(K_RDY, 1'b1, "R7 ready after walk");
    exp_bit(K_DONE, 1'b0, "R5 done one cycle");
    step(); // N18
    ins_valid = 1'b0;
    exp_fwd(20'h00200, 1'b1, 20'h00C00, "R7 stalled insert landed");
    exp_rev(20'h00B01, 1'b1, 20'h00301, "R5 other owner rev kept");
    step();
    exp_fwd(20'h00101, 1'b1, 20'h00A01, "R5 other owner fwd kept");
    exp_rev(20'h00B00, 1'b0, '0, "R5 rev owner cleared");
    step();
    exp_fwd(20'h00100, 1'b0, '0, "R5 fwd owner cleared");

    // fill forward slots 2..15 with owner 5
    for (int i = 0; i < 14; i++)
      insert(1'b0, 20'h00400 + 20'(i), 20'h00D00 + 20'(i), 3'd5, "R2 fill");
    kend(3'd5);
    kend(3'd2);
    exp_fwd(20'h00401, 1'b1, 20'h00D01, "R8 resident after kernel end");
    exp_rev(20'h00B01, 1'b1, 20'h00301, "R8 rev resident");
    step(); // M0: insert into full buffer
    ins_valid = 1'b1; ins_dir = 1'b0; ins_vpn = 20'h00500; ins_ppn = 20'h00E00; ins_map = 3'd6;
    exp_bit(K_RDY, 1'b0, "R9 ready low when full");
    step(); step(); step(); // M3, slot 2
    exp_fwd(20'h00400, 1'b0, '0, "R9 R6 lazy walk kills slot2");
    step(); // M4
    exp_fwd(20'h00402, 1'b1, 20'h00D02, "R6 later slot hits in lazy walk");
    repeat (12) step(); // M16
    exp_bit(K_DONE, 1'b0, "R9 no done for lazy walk");
    step(); // M17
    exp_bit(K_RDY, 1'b1, "R9 ready after lazy walk");
    step(); // M18
    ins_valid = 1'b0;
    exp_fwd(20'h00500, 1'b1, 20'h00E00, "R9 insert landed");
    step();
    exp_fwd(20'h00101, 1'b1, 20'h00A01, "R9 newer queued owner kept");
    step();
    exp_fwd(20'h0040D, 1'b0, '0, "R9 oldest owner cleared");

    // refill slots 3..15, then reclaim next queued owner (2)
    for (int i = 0; i < 13; i++)
      insert(1'b0, 20'h00800 + 20'(i), 20'h00F00 + 20'(i), 3'd7, "R2 fill");
    insert(1'b0, 20'h00600, 20'h00E60, 3'd6, "R10 insert via reclaim");
    exp_fwd(20'h00101, 1'b0, '0, "R10 second queued owner cleared");
    step();
    exp_fwd(20'h00600, 1'b1, 20'h00E60, "R10 new entry hits");
    step();
    exp_fwd(20'h00500, 1'b1, 20'h00E00, "R10 owner 6 kept");
    step();
    exp_fwd(20'h0080C, 1'b1, 20'h00F0C, "R10 owner 7 kept");

    // full and queue empty
    step();
    ins_valid = 1'b1; ins_dir = 1'b0; ins_vpn = 20'h00700; ins_ppn = 20'h00E70; ins_map = 3'd1;
    repeat (30) step();
    exp_bit(K_RDY, 1'b0, "R11 stalled with empty queue");
    exp_fwd(20'h00200, 1'b1, 20'h00C00, "R11 nothing cleared");
    step();
    ins_dir = 1'b1;
    exp_bit(K_RDY, 1'b1, "R11 reverse side ready");
    exp_rev(20'h00B01, 1'b1, 20'h00301, "R11 rev intact");
    step();
    ins_valid = 1'b0;
    repeat (3) step();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule